// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B, and can either pass data straight across or hold it in a register first. Each direction has its own storage register, clock, source select and output enable. A port is not modelled as a tristate net. It appears as an input vector (the resolved pin value), an output vector and a drive flag. The surrounding logic resolves each pin: when the drive flag is set, the transceiver's output wins; otherwise the external driver's value is used.

The A-side register samples the A pins on every rising edge of the A-to-B clock. The B-side register samples the B pins on every rising edge of the B-to-A clock. Capture never depends on the selects or enables. Each output picks either the live value from the opposite bus or the stored register of its own direction. The two enables have opposite polarity: the A-to-B enable is active high and the B-to-A enable is active low. Together these controls give isolation, store-in-both, loop-back hold and simultaneous stored exchange.

Top module: `regxcvr`

## Requirements
- R1: An active-low reset `rst_n` clears both storage registers to zero.
- R2: On each rising edge of `clk_ab` the A register loads `a_in`, whatever the values of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n`.
- R3: On each rising edge of `clk_ba` the B register loads `b_in`, whatever the selects and enables. An edge of `clk_ba` alone leaves the A register unchanged.
- R4: `b_oe` equals `en_ab` (active high). `a_oe` equals the inverse of `en_ba_n` (active low).
- R5: With `en_ab`=0 and `en_ba_n`=1 neither port is driven, and both registers still capture from their pins.
- R6: When B is driven, `sel_ab`=0 puts the live `a_in` on `b_out` and `sel_ab`=1 puts the A register on `b_out`.
- R7: When A is driven, `sel_ba`=0 puts the live `b_in` on `a_out` and `sel_ba`=1 puts the B register on `a_out`.
- R8: With A driven externally and B driven with live A data, one edge on each clock leaves the same A value in both registers.
- R9: With B driven externally and A driven with live B data, one edge on each clock leaves the same B value in both registers.
- R10: With both ports driven and both selects at 0, each bus follows the other. After the external drivers are released, both buses keep their last value.
- R11: With both ports driven and both selects at 1, `b_out` shows the A register and `a_out` shows the B register at the same time.
- R12: An output that is not driven reads zero. Outputs are combinational, with no pipeline delay, in the same cycle as a change of select, enable, pin or register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | Capture clock of the A register |
| clk_ba | input | 1 | Capture clock of the B register |
| en_ab | input | 1 | Drive enable for port B, active high |
| en_ba_n | input | 1 | Drive enable for port A, active low |
| sel_ab | input | 1 | Source of B output: 0 live A, 1 A register |
| sel_ba | input | 1 | Source of A output: 0 live B, 1 B register |
| a_in | input | WIDTH | Resolved value on the A pins |
| a_out | output | WIDTH | Value the block drives onto A |
| a_oe | output | 1 | Block drives port A |
| b_in | input | WIDTH | Resolved value on the B pins |
| b_out | output | WIDTH | Value the block drives onto B |
| b_oe | output | 1 | Block drives port B |

## Verification
Each output is tried with opposing patterns, such as 0x3C on A against 0xC3 on B, so that a swapped mux source or a register captured from the wrong bus shows up at once. All sixteen select and enable combinations are swept, some with clock edges and some without. This separates capture that wrongly depends on the controls from capture that always happens. Directed sequences then cover store-in-both in each direction, stored exchange and loop-back hold after release, with bus keepers modelled by the bench.

// File: rtl/regxcvr.sv
module regxcvr #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             en_ab,
  input  logic             en_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] held_a;
  logic [WIDTH-1:0] held_b;
  logic [WIDTH-1:0] src_b;
  logic [WIDTH-1:0] src_a;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) held_a <= ZERO;
    else        held_a <= a_in;
  end

  AST_A_CAPTURE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    rst_n |=> (held_a == $past(a_in))); // R2

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n) held_b <= ZERO;
    else        held_b <= b_in;
  end

  AST_B_CAPTURE: assert property (@(posedge clk_ba) disable iff (!rst_n)
    rst_n |=> (held_b == $past(b_in))); // R3

  assign b_oe  = en_ab;
  assign a_oe  = ~en_ba_n;
  assign src_b = sel_ab ? held_a : a_in;
  assign src_a = sel_ba ? held_b : b_in;
  assign b_out = b_oe ? src_b : ZERO;
  assign a_out = a_oe ? src_a : ZERO;

  AST_ISOLATE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!en_ab && en_ba_n) |-> (!a_oe && !b_oe && a_out == ZERO && b_out == ZERO)); // R5

  AST_STORED_SWAP: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (en_ab && sel_ab && !en_ba_n && sel_ba) |-> (b_out == held_a && a_out == held_b)); // R11

endmodule

// File: tb/regxcvr_tb.sv
module regxcvr_tb;
  localparam int PERIOD = 40;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_pin = '0, b_pin = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  logic a_drv = 1'b0, b_drv = 1'b0;
  logic [W-1:0] a_ext = '0, b_ext = '0;
  logic [W-1:0] ref_ra = '0, ref_rb = '0;

  logic [2*W+1:0] exp_q[$];
  string          tag_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  regxcvr #(.WIDTH(W)) u_dut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_pin), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_pin), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic settle();
    for (int k = 0; k < 2; k++) begin
      a_pin = a_oe ? a_out : (a_drv ? a_ext : a_pin);
      #1;
      b_pin = b_oe ? b_out : (b_drv ? b_ext : b_pin);
      #1;
    end
  endtask

  task automatic step(input logic eab, input logic eban, input logic sab, input logic sba,
                      input logic ad, input logic [W-1:0] av,
                      input logic bd, input logic [W-1:0] bv,
                      input logic pab, input logic pba, input string tag);
    logic [W-1:0] ea, eb;
    @(posedge clk);
    #1;
    en_ab = eab; en_ba_n = eban; sel_ab = sab; sel_ba = sba;
    a_drv = ad; a_ext = av; b_drv = bd; b_ext = bv;
    settle();
    if (pab) begin clk_ab = 1'b1; ref_ra = a_pin; end
    if (pba) begin clk_ba = 1'b1; ref_rb = b_pin; end
    #1;
    clk_ab = 1'b0; clk_ba = 1'b0;
    settle();
    ea = (!eban) ? (sba ? ref_rb : b_pin) : '0;
    eb = eab ? (sab ? ref_ra : a_pin) : '0;
    exp_q.push_back({ea, !eban, eb, eab});
    tag_q.push_back(tag);
  endtask

  task automatic check_pins(input logic [W-1:0] ea, input logic [W-1:0] eb, input string tag);
    @(negedge clk);
    checks++;
    if (a_pin !== ea || b_pin !== eb) begin
      fails++;
      $display("FAIL %s pins a=%h b=%h expected a=%h b=%h", tag, a_pin, b_pin, ea, eb);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2*W+1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({a_out, a_oe, b_out, b_oe} !== e) begin
        fails++;
        $display("FAIL %s a_out=%h a_oe=%b b_out=%h b_oe=%b expected a_out=%h a_oe=%b b_out=%h b_oe=%b",
                 t, a_out, a_oe, b_out, b_oe, e[2*W+1:W+2], e[W+1], e[W:1], e[0]);
      end
    end
  end

  initial begin
    #(PERIOD*5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 R11: stored view after reset reads zero on both
    step(1, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R1_reset_stored");
    // R5 R4 R12: isolation, capture still happens
    step(0, 1, 0, 0, 1, 8'h3C, 1, 8'hC3, 1, 1, "R5_isolation");
    step(1, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R11_swap_after_isolation");
    // R6 live A to B
    step(1, 1, 0, 0, 1, 8'hA5, 0, 8'h00, 0, 0, "R6_live_a_to_b");
    step(1, 1, 0, 0, 1, 8'hA5, 0, 8'h00, 1, 1, "R8_store_both_a");
    step(1, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R8_view_both_a");
    // R7 live B to A
    step(0, 0, 0, 0, 0, 8'h00, 1, 8'h5A, 0, 0, "R7_live_b_to_a");
    step(0, 0, 0, 0, 0, 8'h00, 1, 8'h5A, 1, 1, "R9_store_both_b");
    step(1, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R9_view_both_b");
    // R2 capture visible same cycle on stored path
    step(1, 1, 1, 0, 1, 8'h11, 0, 8'h00, 1, 0, "R2_capture_stored_path");
    // R2 R3 capture with everything disabled
    step(0, 1, 1, 1, 1, 8'h22, 1, 8'h33, 1, 1, "R3_capture_disabled");
    step(0, 1, 1, 1, 1, 8'h44, 1, 8'h55, 0, 1, "R3_only_b_clock");
    step(1, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R3_view_a_kept_b_new");
    // R12 combinational select change
    step(1, 0, 0, 1, 1, 8'h66, 1, 8'h99, 0, 0, "R12_select_change");
    // R10 loop-back hold
    step(1, 1, 0, 0, 1, 8'h77, 0, 8'h00, 0, 0, "R10_prime");
    step(1, 0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R10_loop_release");
    check_pins(8'h77, 8'h77, "R10_pins_hold");
    step(1, 0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, "R10_loop_capture");
    step(1, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R10_view_regs");
    // R4 R6 R7: sweep of all select and enable combinations
    for (int i = 0; i < 16; i++) begin
      step(i[3], i[2], i[1], i[0], 1, 8'h0F + 8'(i), 1, 8'hF0 - 8'(i), i[0], i[1], "R4_sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule